// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block drives a display panel's supply rails through a fixed series of control-register writes. A level input asks for the panel to be powered or unpowered. The block compares that request with the power state it last reached. When the two differ, it walks through the matching step list and passes each register write to a downstream serial register-access engine. After selected writes it waits a programmed number of milliseconds before going on. The millisecond waits are turned into clock cycles from a clock-frequency parameter. Each cycle count is rounded up, so no wait is ever shorter than its nominal time.

The power-up list has nine steps:
- `0x10←0x0000` (wait 10 ms)
- `0x11←0x0000`
- `0x12←0x0000` (wait 40 ms)
- `0x13←0x0000` (wait 40 ms)
- `0x56←0x080F`
- `0x10←0x4240` (wait 10 ms)
- `0x11←0x0000`
- `0x12←0x0014` (wait 40 ms)
- `0x13←0x1319` (wait 40 ms)

The power-down list is the first four of these steps. If a write reports an error, the block records it and still runs the list to the end. It then pulses done together with an error flag and leaves the stored state unchanged. Reset leaves the stored state at off. A system that holds the request high therefore powers the panel up as soon as reset is released.

The state machine has five states:
- IDLE: compares the request with the stored state.
- REQ: holds a write request until the engine answers.
- DELAY: counts down a wait.
- ADV: a single-cycle gap that selects the next step or ends the list.
- FINISH: single cycle that pulses done.

Its transitions are:
- IDLE→REQ when the request differs from the stored state.
- REQ→DELAY when the write completes and the step has a wait.
- REQ→ADV when the write completes and the step has no wait.
- DELAY→ADV when the count expires.
- ADV→REQ when more steps remain.
- ADV→FINISH after the last step.
- FINISH→IDLE unconditionally.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset `pwr_state` is 0 (off), and `busy`, `done`, `err` and `wr_valid` are 0.
- R2: A sequence starts only when `pwr_req` differs from `pwr_state`. While they are equal, no write is requested and no done is pulsed.
- R3: With `pwr_req`=1 and state off, exactly nine writes are issued, with (address, data) in this order: (0x10,0x0000) (0x11,0x0000) (0x12,0x0000) (0x13,0x0000) (0x56,0x080F) (0x10,0x4240) (0x11,0x0000) (0x12,0x0014) (0x13,0x1319).
- R4: With `pwr_req`=0 and state on, exactly four writes are issued: (0x10,0x0000) (0x11,0x0000) (0x12,0x0000) (0x13,0x0000).
- R5: Let N = ceil(CLK_HZ·ms/1000) cycles. A write to 0x10 waits N for 10 ms, and a write to 0x12 or 0x13 waits N for 40 ms. The next request, or done after the last write, rises exactly N+2 cycles after the cycle in which `wr_done` was high. After a write with no wait, it rises exactly 2 cycles after.
- R6: `wr_valid` stays high with stable `wr_addr`/`wr_data` until `wr_done`, and is low for at least one cycle between two writes.
- R7: A `wr_err` on any write does not stop the list. Every write of the list is issued, and `err` is pulsed together with `done` if any write failed.
- R8: `pwr_state` changes only in the cycle after an error-free done. It takes the requested value then and is unchanged after a done with error.
- R9: The direction is latched when a sequence starts. Changes of `pwr_req` while `busy` do not change the issued list or the outcome.
- R10: `busy` is high from the first request through the done cycle. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Requested power state (1 = on) |
| wr_done | input | 1 | Engine finished the current write (one-cycle pulse) |
| wr_err | input | 1 | Error status of the write, valid with `wr_done` |
| wr_valid | output | 1 | Write request to the register engine |
| wr_addr | output | 8 | Register address of the requested write |
| wr_data | output | 16 | Value of the requested write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| err | output | 1 | At least one write of the finished sequence failed |
| pwr_state | output | 1 | Stored power state (1 = on) |

## Verification
The assertions check the local rules on every cycle:
- the request stays stable until its answer and drops between writes;
- done and err are single pulses, with err only alongside done;
- the stored state moves only just after an error-free done;
- the direction does not change while busy;
- the wait counter never re-arms on its own.

Only the bench scenarios can show whole-sequence behaviour:
- the exact order of addresses and values for each direction;
- the exact gaps that follow each wait;
- that a failure in the middle of the list still runs the list to its end;
- that an equal request, or one that toggles while busy, produces no extra writes.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

    localparam int REG_AW    = 8;
    localparam int REG_DW    = 16;
    localparam int STEPS_ON  = 9;
    localparam int STEPS_OFF = 4;
    localparam int IDX_W     = $clog2(STEPS_ON);

    typedef enum logic [1:0] {
        DLY_NONE  = 2'd0,
        DLY_SHORT = 2'd1,
        DLY_LONG  = 2'd2
    } dly_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
        dly_e              dly;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_REQ    = 3'd1,
        S_DELAY  = 3'd2,
        S_ADV    = 3'd3,
        S_FINISH = 3'd4
    } st_e;

endpackage

// File: rtl/pwr_seq_rom.sv
`timescale 1ns/1ps
module pwr_seq_rom
    import pwr_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // The power-down list is the prefix 0..STEPS_OFF-1 of this table.
    always_comb begin
        step = '{addr: 8'h00, data: 16'h0000, dly: DLY_NONE};
        unique case (idx)
            IDX_W'(0): step = '{addr: 8'h10, data: 16'h0000, dly: DLY_SHORT};
            IDX_W'(1): step = '{addr: 8'h11, data: 16'h0000, dly: DLY_NONE};
            IDX_W'(2): step = '{addr: 8'h12, data: 16'h0000, dly: DLY_LONG};
            IDX_W'(3): step = '{addr: 8'h13, data: 16'h0000, dly: DLY_LONG};
            IDX_W'(4): step = '{addr: 8'h56, data: 16'h080F, dly: DLY_NONE};
            IDX_W'(5): step = '{addr: 8'h10, data: 16'h4240, dly: DLY_SHORT};
            IDX_W'(6): step = '{addr: 8'h11, data: 16'h0000, dly: DLY_NONE};
            IDX_W'(7): step = '{addr: 8'h12, data: 16'h0014, dly: DLY_LONG};
            IDX_W'(8): step = '{addr: 8'h13, data: 16'h1319, dly: DLY_LONG};
            default:   step = '{addr: 8'h00, data: 16'h0000, dly: DLY_NONE};
        endcase
    end

endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SHORT_MS = 10,
    parameter int LONG_MS  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  dly_e sel,
    output logic expire
);

    // Rounded up so that every wait is at least its nominal length.
    localparam longint SHORT_CYC = (longint'(CLK_HZ) * SHORT_MS + 999) / 1000;
    localparam longint LONG_CYC  = (longint'(CLK_HZ) * LONG_MS + 999) / 1000;
    localparam longint MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int     CNT_W     = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (sel == DLY_LONG) ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

    AST_TMR_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !load |=> !expire);  // R5

    AST_TMR_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) && !load |=> (cnt_q == '0));  // R5

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SHORT_MS = 10,
    parameter int LONG_MS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_req,
    input  logic              wr_done,
    input  logic              wr_err,
    output logic              wr_valid,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              pwr_state
);

    localparam logic [IDX_W-1:0] LAST_ON  = IDX_W'(STEPS_ON - 1);
    localparam logic [IDX_W-1:0] LAST_OFF = IDX_W'(STEPS_OFF - 1);

    st_e              st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic             dir_q;
    logic             err_acc_q;
    logic             state_q;
    step_t            step;
    logic             last_step;
    logic             tmr_load;
    logic             tmr_expire;

    pwr_seq_rom u_rom (
        .idx  (idx_q),
        .step (step)
    );

    pwr_seq_timer #(
        .CLK_HZ   (CLK_HZ),
        .SHORT_MS (SHORT_MS),
        .LONG_MS  (LONG_MS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .sel    (step.dly),
        .expire (tmr_expire)
    );

    assign last_step = (idx_q == (dir_q ? LAST_ON : LAST_OFF));
    assign tmr_load  = (st_q == S_REQ) && wr_done && (step.dly != DLY_NONE);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (pwr_req != state_q) st_d = S_REQ;
            S_REQ:    if (wr_done) st_d = (step.dly != DLY_NONE) ? S_DELAY : S_ADV;
            S_DELAY:  if (tmr_expire) st_d = S_ADV;
            S_ADV:    st_d = last_step ? S_FINISH : S_REQ;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Sequence bookkeeping: direction, step index, error sum, stored state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            dir_q     <= 1'b0;
            err_acc_q <= 1'b0;
            state_q   <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (pwr_req != state_q) begin
                        dir_q     <= pwr_req;
                        idx_q     <= '0;
                        err_acc_q <= 1'b0;
                    end
                end
                S_REQ: begin
                    if (wr_done) err_acc_q <= err_acc_q | wr_err;
                end
                S_ADV: begin
                    if (!last_step) idx_q <= idx_q + 1'b1;
                end
                S_FINISH: begin
                    if (!err_acc_q) state_q <= dir_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_valid  = (st_q == S_REQ);
        wr_addr   = step.addr;
        wr_data   = step.data;
        busy      = (st_q != S_IDLE);
        done      = (st_q == S_FINISH);
        err       = (st_q == S_FINISH) && err_acc_q;
        pwr_state = state_q;
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_done |=> wr_valid && $stable(wr_addr) && $stable(wr_data));  // R6

    AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_done |=> !wr_valid);  // R6

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);  // R7

    AST_STATE_ON_CLEAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_state) |-> $past(done) && !$past(err));  // R8

    AST_DIR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(dir_q));  // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid && !done);  // R2

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;

    localparam int CLK_HZ  = 1000;   // scaled: one cycle per millisecond
    localparam int SHORT_N = (CLK_HZ * 10 + 999) / 1000;
    localparam int LONG_N  = (CLK_HZ * 40 + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_req = 1'b0;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;
    logic        wr_valid;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        busy, done, err, pwr_state;

    pwr_seq_ctrl #(.CLK_HZ(CLK_HZ), .SHORT_MS(10), .LONG_MS(40)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .wr_done(wr_done),
        .wr_err(wr_err), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .err(err),
        .pwr_state(pwr_state)
    );

    always #4 clk = ~clk;   // 125 MHz

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0]  la [64];
    logic [15:0] ld [64];
    int lrise [64];
    int ldone [64];
    int nlog = 0;
    int ndone = 0;
    int done_t = 0;
    bit done_err = 1'b0;
    bit state_at_done = 1'b0;
    bit busy_bad = 1'b0;
    bit hold_bad = 1'b0;
    int err_at = -1;
    int lat = 0;
    bit prev_valid = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_addr(input int i);
        case (i)
            0, 5: return 8'h10;
            1, 6: return 8'h11;
            2, 7: return 8'h12;
            3, 8: return 8'h13;
            default: return 8'h56;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input int i);
        case (i)
            4: return 16'h080F;
            5: return 16'h4240;
            7: return 16'h0014;
            8: return 16'h1319;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int exp_gap(input int i);
        logic [7:0] a;
        a = exp_addr(i);
        if (a == 8'h10) return SHORT_N + 2;
        if (a == 8'h12 || a == 8'h13) return LONG_N + 2;
        return 2;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Register-engine model and monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && !busy) busy_bad = 1'b1;
            if (wr_valid && prev_valid && !wr_done &&
                (wr_addr != la[nlog] || wr_data != ld[nlog])) hold_bad = 1'b1;
            if (wr_done) begin
                wr_done = 1'b0;
                wr_err  = 1'b0;
            end else if (wr_valid) begin
                if (!prev_valid && nlog < 64) begin
                    lrise[nlog] = cyc;
                    la[nlog] = wr_addr;
                    ld[nlog] = wr_data;
                    lat = $urandom_range(0, 3);
                end
                if (lat == 0) begin
                    ldone[nlog] = cyc;
                    wr_done = 1'b1;
                    wr_err  = (nlog == err_at);
                    nlog++;
                end else begin
                    lat--;
                end
            end
            if (done) begin
                ndone++;
                done_t = cyc;
                done_err = err;
                state_at_done = pwr_state;
            end
            prev_valid = wr_valid;
        end
    end

    task automatic clear_log();
        nlog = 0; ndone = 0; busy_bad = 1'b0; hold_bad = 1'b0;
    endtask

    // Run one transition toward req; err_idx < 0 means no error injected.
    task automatic run_seq(input bit req, input int err_idx, input int glitch_at);
        bit old_state;
        int n;
        int guard;
        bit exp_err;
        old_state = pwr_state;
        n = req ? 9 : 4;
        exp_err = (err_idx >= 0) && (err_idx < n);
        clear_log();
        err_at = err_idx;
        @(negedge clk);
        pwr_req = req;
        guard = 0;
        while (ndone == 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (glitch_at >= 0 && nlog == glitch_at)     pwr_req = !req;
            if (glitch_at >= 0 && nlog == glitch_at + 2) pwr_req = req;
        end
        chk(ndone == 1, "R10", "done pulses", ndone, 1);
        if (exp_err) pwr_req = old_state;
        chk(nlog == n, req ? "R3" : "R4", "write count", nlog, n);
        for (int i = 0; i < n && i < nlog; i++) begin
            chk(la[i] == exp_addr(i), req ? "R3" : "R4", "address", la[i], exp_addr(i));
            chk(ld[i] == exp_data(i), req ? "R3" : "R4", "data", ld[i], exp_data(i));
            if (i + 1 < nlog)
                chk(lrise[i+1] - ldone[i] == exp_gap(i), "R5", "gap to next write",
                    lrise[i+1] - ldone[i], exp_gap(i));
        end
        if (nlog == n)
            chk(done_t - ldone[n-1] == exp_gap(n-1), "R5", "gap to done",
                done_t - ldone[n-1], exp_gap(n-1));
        chk(done_err == exp_err, "R7", "err at done", done_err, exp_err);
        chk(state_at_done == old_state, "R8", "state during done", state_at_done, old_state);
        chk(!busy_bad, "R10", "request while not busy", busy_bad, 0);
        chk(!hold_bad, "R6", "request changed before answer", hold_bad, 0);
        repeat (3) @(negedge clk);
        chk(pwr_state == (exp_err ? old_state : req), "R8", "state after done",
            pwr_state, exp_err ? old_state : req);
        chk(!busy, "R10", "busy after done", busy, 0);
        err_at = -1;
    endtask

    task automatic run_noop(input bit req);
        clear_log();
        @(negedge clk);
        pwr_req = req;
        repeat (60) @(negedge clk);
        chk(nlog == 0, "R2", "writes with equal request", nlog, 0);
        chk(ndone == 0, "R2", "done with equal request", ndone, 0);
        chk(!busy, "R2", "busy with equal request", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(pwr_state == 1'b0, "R1", "reset state", pwr_state, 0);
        chk(!busy && !done && !err && !wr_valid, "R1", "reset outputs",
            {busy, done, err, wr_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pwr_state == 1'b0 && !busy, "R1", "state after reset", pwr_state, 0);

        run_noop(1'b0);                 // R2 off request while off
        run_seq(1'b1, -1, -1);          // R3 power up
        run_noop(1'b1);                 // R2 on request while on
        run_seq(1'b0, -1, -1);          // R4 power down
        run_seq(1'b1, 6, -1);           // R7 error in the middle, state stays off
        run_seq(1'b1, 8, -1);           // R7 error on last write
        run_seq(1'b1, -1, 2);           // R9 request toggles while busy
        run_seq(1'b0, 0, -1);           // R7 error on first power-down write
        run_seq(1'b0, -1, 1);           // R9 toggle during power down

        for (int r = 0; r < 10; r++) begin
            bit req;
            int eidx;
            req  = 1'($urandom_range(0, 1));
            eidx = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 8)) : -1;
            if (req == pwr_state) run_noop(req);
            else                  run_seq(req, eidx, -1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule